// File: doc/BRIEF.md
# Posted Write Buffer

This block sits between a write-back cache or processor and slow main memory. It absorbs writes at full processor rate and empties them to memory in the background. Each upstream request carries a line-aligned word address and one to `LINE_WORDS` data words. The words are captured in a single clock, so a single store and a whole evicted cache line are treated alike. Pending writes occupy two separate pools: address slots, one per request, and a shared ring of data words. The writer is held off as soon as either pool cannot take the request.

The memory side is a valid/ready stream that carries one word per beat. Word addresses count up from the entry's base, and a last flag marks the final word of each entry. Entries leave strictly in arrival order and only on a completed handshake. A write marked non-bufferable never enters the buffer. It waits until the buffer is empty and is then passed straight through to the memory port. Buffered data cannot be read back. Instead, a read-line probe reports whether a read must be held off until a matching pending write has reached memory.

Back-pressure rules: on the upstream side, the writer must keep `wr_valid` and every request field steady until `wr_ready` is high. On the memory side, a beat that comes from the buffer keeps `mem_valid` and its payload steady until `mem_ready` is high. A pass-through beat follows the upstream request, and that request is held by the same upstream rule.

Top module: `posted_wbuf`

## Requirements
- R1: After reset `buf_empty` is 1, `mem_valid` is 0 and `rd_hold` is 0, and a one-word bufferable request sees `wr_ready` = 1.
- R2: A bufferable request is accepted in the cycle it is offered (`wr_ready` = 1) whenever fewer than `ADDR_SLOTS` entries are pending and the free data words are at least `wr_words` (legal range 1 to `LINE_WORDS`). Acceptance and draining may happen in the same cycle.
- R3: With `ADDR_SLOTS` entries pending, a bufferable request sees `wr_ready` = 0.
- R4: With an address slot free but fewer free data words than `wr_words`, a bufferable request sees `wr_ready` = 0.
- R5: While the buffer is not empty, `mem_valid` is 1 and the memory port carries the oldest entry's words in order. Beat k has address base+k and the entry's k-th data word (word k occupies `wr_data` bits [32k+31:32k]). `mem_last` = 1 only on the final word.
- R6: A buffered beat that is not accepted keeps `mem_valid`, `mem_addr`, `mem_data` and `mem_last` unchanged in the next cycle.
- R7: A non-bufferable request sees `wr_ready` = 0 while anything is pending. Once the buffer is empty it appears on the memory port in the same cycle with `wr_addr`, word 0 of `wr_data` and `mem_last` = 1; `wr_words` is ignored, and `wr_ready` equals `mem_ready`.
- R8: `rd_hold` is 1 exactly when `rd_line` equals the line address (`wr_addr` bits above the word offset) of some pending entry. It drops once that entry has fully drained.
- R9: `buf_empty` is 1 exactly when no entry is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Request accepted this cycle; low means stall |
| wr_bufferable | input | 1 | 1: may be posted, 0: pass-through |
| wr_addr | input | AW | Line-aligned word address |
| wr_words | input | CW | Number of words, 1 to LINE_WORDS |
| wr_data | input | LINE_WORDS*DW | Data words, word 0 in the low bits |
| mem_valid | output | 1 | Memory write beat present |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | AW | Word address of the beat |
| mem_data | output | DW | Data word of the beat |
| mem_last | output | 1 | Final word of an entry |
| rd_line | input | AW-OFF_W | Line address of a pending read |
| rd_hold | output | 1 | Read must wait for a pending write |
| buf_empty | output | 1 | Nothing pending |

## Verification
The bench targets the two separate capacity limits. It fills every address slot with one-word entries, and it fills the data ring with two full lines while slots are still free. A design that checked only one limit would either overwrite queued words or stall needlessly. A non-bufferable write is offered behind a posted entry. A wrong design would let it overtake the buffered write or lose it. Long random runs with back-pressure check each beat's address, data and last flag against a model queue. They also check that probes of every line raise and drop `rd_hold`. A design that drops the hold one beat early, or repeats or skips a word under a stalled `mem_ready`, shows up as a mismatch.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic {SRC_BUF, SRC_PASS} mem_src_e;
endpackage

// File: rtl/wbuf_data_q.sv
module wbuf_data_q #(
  parameter int DW = 32,
  parameter int LINE_WORDS = 4,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(LINE_WORDS + 1),
  localparam int PW = $clog2(DEPTH),
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [CW-1:0]            push_n,
  input  logic [LINE_WORDS*DW-1:0] push_data,
  input  logic                     pop,
  output logic [DW-1:0]            head,
  output logic [NW-1:0]            free
);
  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] used;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      used <= '0;
    end else begin
      if (push) wp <= wp + PW'(push_n);
      if (pop) rp <= rp + PW'(1);
      used <= used + (push ? NW'(push_n) : '0) - (pop ? NW'(1) : '0);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINE_WORDS; i++)
      if (push && (CW'(i) < push_n))
        store[wp + PW'(i)] <= push_data[i*DW +: DW];
  end

  assign head = store[rp];
  assign free = NW'(DEPTH) - used;

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (NW'(push_n) <= free));
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (used != '0));
endmodule

// File: rtl/wbuf_addr_q.sv
module wbuf_addr_q #(
  parameter int AW = 16,
  parameter int LINE_WORDS = 4,
  parameter int SLOTS = 4,
  localparam int CW = $clog2(LINE_WORDS + 1),
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int PW = $clog2(SLOTS),
  localparam int NW = $clog2(SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [AW-1:0]       push_addr,
  input  logic [CW-1:0]       push_n,
  input  logic                pop,
  output logic [AW-1:0]       head_addr,
  output logic [CW-1:0]       head_n,
  output logic [NW-1:0]       count,
  input  logic [AW-OFF_W-1:0] rd_line,
  output logic                hit
);
  logic [AW-1:0] addr_r [SLOTS];
  logic [CW-1:0] n_r [SLOTS];
  logic [PW-1:0] wp, rp;
  logic [SLOTS-1:0] match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + PW'(1);
      if (pop) rp <= rp + PW'(1);
      count <= count + (push ? NW'(1) : '0) - (pop ? NW'(1) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_r[wp] <= push_addr;
      n_r[wp] <= push_n;
    end
  end

  for (genvar j = 0; j < SLOTS; j++) begin : g_cmp
    logic [PW-1:0] age;
    assign age = PW'(j) - rp;
    assign match[j] = (NW'(age) < count) && (addr_r[j][AW-1:OFF_W] == rd_line);
  end

  assign hit = |match;
  assign head_addr = addr_r[rp];
  assign head_n = n_r[rp];

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < NW'(SLOTS)));
  a_r8_hit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (count != '0));
endmodule

// File: rtl/posted_wbuf.sv
module posted_wbuf #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LINE_WORDS = 4,
  parameter int ADDR_SLOTS = 4,
  parameter int DATA_WORDS = 8,
  localparam int CW = $clog2(LINE_WORDS + 1),
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int SNW = $clog2(ADDR_SLOTS + 1),
  localparam int DNW = $clog2(DATA_WORDS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic                     wr_bufferable,
  input  logic [AW-1:0]            wr_addr,
  input  logic [CW-1:0]            wr_words,
  input  logic [LINE_WORDS*DW-1:0] wr_data,
  output logic                     mem_valid,
  input  logic                     mem_ready,
  output logic [AW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_data,
  output logic                     mem_last,
  input  logic [AW-OFF_W-1:0]      rd_line,
  output logic                     rd_hold,
  output logic                     buf_empty
);
  import wbuf_pkg::*;

  logic [AW-1:0]  head_addr;
  logic [CW-1:0]  head_n, beat;
  logic [SNW-1:0] slots_used;
  logic [DNW-1:0] words_free;
  logic [DW-1:0]  head_word;
  logic room, push, drain, last_beat;
  mem_src_e src;

  assign buf_empty = (slots_used == '0);
  assign room = (slots_used < SNW'(ADDR_SLOTS)) && (words_free >= DNW'(wr_words));
  assign wr_ready = wr_bufferable ? room : (buf_empty && mem_ready);
  assign push = wr_valid && wr_bufferable && room;
  assign src = buf_empty ? SRC_PASS : SRC_BUF;
  assign last_beat = (beat == head_n - CW'(1));
  assign drain = (src == SRC_BUF) && mem_ready;

  always_comb begin
    if (src == SRC_BUF) begin
      mem_valid = 1'b1;
      mem_addr  = head_addr + AW'(beat);
      mem_data  = head_word;
      mem_last  = last_beat;
    end else begin
      mem_valid = wr_valid && !wr_bufferable;
      mem_addr  = wr_addr;
      mem_data  = wr_data[DW-1:0];
      mem_last  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) beat <= '0;
    else if (drain) beat <= last_beat ? '0 : beat + CW'(1);
  end

  wbuf_addr_q #(.AW(AW), .LINE_WORDS(LINE_WORDS), .SLOTS(ADDR_SLOTS)) i_addr_q (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(wr_addr), .push_n(wr_words),
    .pop(drain && last_beat), .head_addr(head_addr), .head_n(head_n),
    .count(slots_used), .rd_line(rd_line), .hit(rd_hold));

  wbuf_data_q #(.DW(DW), .LINE_WORDS(LINE_WORDS), .DEPTH(DATA_WORDS)) i_data_q (
    .clk(clk), .rst_n(rst_n), .push(push), .push_n(wr_words), .push_data(wr_data),
    .pop(drain), .head(head_word), .free(words_free));

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_empty && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_last)));
  a_r7_pass_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_bufferable && wr_ready) |-> (buf_empty && mem_valid && mem_last));
  a_r9_empty_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> !rd_hold);
  a_r2_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_bufferable && wr_ready) |=> !buf_empty);
endmodule

// File: tb/test_posted_wbuf.sv
`timescale 1ns/1ps
module test_posted_wbuf;
  localparam int CYC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_bufferable = 1'b1, mem_ready = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [2:0] wr_words = 3'd1;
  logic [127:0] wr_data = '0;
  logic [13:0] rd_line = '0;
  logic wr_ready, mem_valid, mem_last, rd_hold, buf_empty;
  logic [15:0] mem_addr;
  logic [31:0] mem_data;

  always #(CYC/2) clk = ~clk;

  posted_wbuf i_posted_wbuf (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_bufferable(wr_bufferable), .wr_addr(wr_addr), .wr_words(wr_words),
    .wr_data(wr_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_last(mem_last),
    .rd_line(rd_line), .rd_hold(rd_hold), .buf_empty(buf_empty));

  typedef struct packed {logic [15:0] a; logic [2:0] n; logic [127:0] d;} ent_t;
  ent_t q[$];
  int beat = 0, dcnt = 0, checks = 0, fails = 0;
  bit accepted = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  function automatic bit exp_hold(input logic [13:0] line);
    foreach (q[i]) if (q[i].a[15:2] == line) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [48:0] exp_beat();
    ent_t h = q[0];
    return {h.a + 16'(beat), h.d[beat*32 +: 32], 1'(beat == int'(h.n) - 1)};
  endfunction

  // called at a negedge with inputs set; checks before the edge, updates model after
  task automatic cycle();
    bit empty_m, room, rdy, mv;
    string tag;
    #2;
    empty_m = (q.size() == 0);
    room = (q.size() < 4) && ((8 - dcnt) >= int'(wr_words));
    rdy = wr_bufferable ? room : (empty_m && mem_ready);
    if (!wr_bufferable) tag = "R7";
    else if (q.size() == 4) tag = "R3";
    else if (!room) tag = "R4";
    else tag = "R2";
    chk(wr_ready == rdy, tag, 64'(wr_ready), 64'(rdy));
    mv = !empty_m || (wr_valid && !wr_bufferable);
    chk(mem_valid == mv, empty_m ? "R7" : "R5", 64'(mem_valid), 64'(mv));
    if (mv) begin
      logic [48:0] e = empty_m ? {wr_addr, wr_data[31:0], 1'b1} : exp_beat();
      chk({mem_addr, mem_data, mem_last} == e,
          empty_m ? "R7" : (mem_ready ? "R5" : "R6"),
          64'({mem_addr, mem_data, mem_last}), 64'(e));
    end
    chk(rd_hold == exp_hold(rd_line), "R8", 64'(rd_hold), 64'(exp_hold(rd_line)));
    chk(buf_empty == empty_m, "R9", 64'(buf_empty), 64'(empty_m));
    accepted = wr_valid && rdy;
    @(posedge clk);
    if (!empty_m && mem_ready) begin
      beat++;
      dcnt--;
      if (beat == int'(q[0].n)) begin
        void'(q.pop_front());
        beat = 0;
      end
    end
    if (wr_valid && wr_bufferable && rdy) begin
      q.push_back('{a: wr_addr, n: wr_words, d: wr_data});
      dcnt += int'(wr_words);
    end
    @(negedge clk);
  endtask

  task automatic offer(input bit bufable, input int line, input int n);
    wr_valid = 1'b1;
    wr_bufferable = bufable;
    wr_addr = 16'(line * 4);
    wr_words = 3'(n);
    wr_data = {$urandom(), $urandom(), $urandom(), $urandom()};
  endtask

  initial begin
    #(CYC * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    chk(buf_empty == 1'b1, "R1", 64'(buf_empty), 64'd1);
    chk(mem_valid == 1'b0, "R1", 64'(mem_valid), 64'd0);
    chk(rd_hold == 1'b0, "R1", 64'(rd_hold), 64'd0);
    chk(wr_ready == 1'b1, "R1", 64'(wr_ready), 64'd1);
    @(negedge clk);

    // R3: fill all address slots with one-word entries, then one more stalls
    mem_ready = 1'b0;
    for (int i = 0; i < 5; i++) begin
      offer(1'b1, i, 1);
      cycle();
    end
    chk(wr_ready == 1'b0, "R3", 64'(wr_ready), 64'd0);
    wr_valid = 1'b0;
    rd_line = 14'd2;
    cycle();
    chk(rd_hold == 1'b1, "R8", 64'(rd_hold), 64'd1);
    mem_ready = 1'b1;
    for (int i = 0; i < 4; i++) cycle();
    chk(rd_hold == 1'b0, "R8", 64'(rd_hold), 64'd0);
    chk(buf_empty == 1'b1, "R9", 64'(buf_empty), 64'd1);

    // R4: two full lines exhaust the data ring while slots remain free
    mem_ready = 1'b0;
    offer(1'b1, 5, 4); cycle();
    offer(1'b1, 6, 4); cycle();
    offer(1'b1, 7, 1); cycle();
    chk(wr_ready == 1'b0, "R4", 64'(wr_ready), 64'd0);
    wr_valid = 1'b0;
    mem_ready = 1'b1;
    for (int i = 0; i < 8; i++) cycle();

    // R7: pass-through request waits behind a posted entry
    mem_ready = 1'b0;
    offer(1'b1, 9, 2); cycle();
    offer(1'b0, 10, 3);
    cycle(); cycle();
    mem_ready = 1'b1;
    while (!accepted) cycle();
    wr_valid = 1'b0;
    cycle();

    // random traffic with varying back-pressure
    for (int phase = 0; phase < 4; phase++) begin
      int pct = 25 + phase * 25;
      for (int k = 0; k < 1500; k++) begin
        if (!(wr_valid && !accepted)) begin
          if ($urandom() % 4 != 0) offer(($urandom() % 6) != 0, int'($urandom() % 8), 1 + int'($urandom() % 4));
          else wr_valid = 1'b0;
        end
        mem_ready = ($urandom() % 100) < 32'(pct);
        rd_line = 14'($urandom() % 8);
        cycle();
      end
    end
    wr_valid = 1'b0;
    mem_ready = 1'b1;
    for (int i = 0; i < 20; i++) cycle();
    chk(buf_empty == 1'b1, "R9", 64'(buf_empty), 64'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule